// File: doc/BRIEF.md
# DMA Stream Termination and Flow-Control Unit

This block governs the lifetime of one DMA stream: when it may start, how its data-item counter moves, and which of several events ends it. Either the DMA itself or the attached peripheral controls the flow. When the DMA controls the flow, the counter starts from the value software wrote and the stream ends when the counter reaches zero. In circular mode the counter is reloaded and the stream keeps running. When the peripheral controls the flow, the counter is preset to its all-ones value at start. The peripheral then ends the stream by announcing its final single or burst request. The number of items moved is the all-ones value minus the remaining count.

Software starts the stream by writing an enable. It stops the stream early by writing the enable as zero. For a peripheral-to-memory stream, an early stop also requests a FIFO flush. Before a start is accepted, the unit checks the requested configuration. An illegal configuration raises a sticky error, and the stream does not start. Every termination raises a sticky transfer-complete flag, which software clears by writing 1. After any termination the stream reads as inactive until software enables it again.

Top module: `dma_term_unit`

## Requirements
- R1: After reset the stream is inactive, the count is 0, and transfer-complete, configuration-error and flush request are all 0.
- R2: An enable write while the stream is inactive is rejected under any of these conditions: direction code 11; peripheral flow effective together with circular or double-buffer; direction 10 together with circular, double-buffer or direct mode; direct mode together with burst type; DMA flow together with a count of 0. A rejected enable sets the sticky configuration error and leaves the stream inactive. A write of 1 to the error-clear input clears the error.
- R3: In direction 10 (memory to memory) the effective peripheral-flow bit reads 0, whatever was requested.
- R4: Under DMA flow, the count starts from the written value and drops by one on each completed data-item handshake while the stream is active. A count write while the stream is active is ignored.
- R5: Accepting an enable under peripheral flow sets the count to 2^CNT_W-1, whatever value software wrote.
- R6: When a handshake brings the count to 0 in a non-circular stream, the stream goes inactive at that edge and transfer-complete is set. Under peripheral flow this happens even if no last request was seen.
- R7: In a circular DMA-flow stream, reaching 0 reloads the written count and sets transfer-complete. The stream stays active.
- R8: Under peripheral flow, a last-single or last-burst request does not stop the stream by itself. The stream stops, and transfer-complete is set, at the end-of-transaction strobe of that final transfer. The items moved then equal 2^CNT_W-1 minus the count. Under DMA flow, last requests are ignored.
- R9: An enable write of 0 while the stream is active stops it and sets transfer-complete. For direction 00 (peripheral to memory) it also gives a one-cycle flush request in the next cycle. For any other direction there is no flush.
- R10: Transfer-complete stays set until a clear pulse arrives. A set event wins over a clear in the same cycle. After termination, handshakes do not restart the stream or change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control write strobe |
| cfg_en | input | 1 | Enable value written with cfg_wr |
| cfg_dir | input | 2 | Direction: 00 periph→mem, 01 mem→periph, 10 mem→mem, 11 reserved |
| cfg_pfc | input | 1 | Peripheral-is-flow-controller request |
| cfg_circ | input | 1 | Circular mode |
| cfg_direct | input | 1 | Direct (FIFO bypass) mode |
| cfg_dbuf | input | 1 | Double-buffer mode |
| cfg_burst | input | 1 | Transfer type: 1 burst, 0 single |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | CNT_W | Count write value |
| tc_clr | input | 1 | Write-1 clear of transfer-complete |
| err_clr | input | 1 | Write-1 clear of configuration error |
| beat_done | input | 1 | One data item completed |
| xfer_done | input | 1 | Current single or burst transaction completed |
| last_sreq | input | 1 | Peripheral final single request |
| last_breq | input | 1 | Peripheral final burst request |
| active | output | 1 | Stream enabled (reads back as the enable) |
| count | output | CNT_W | Live remaining data-item count |
| tc_flag | output | 1 | Sticky transfer-complete |
| cfg_err | output | 1 | Sticky configuration error |
| flush_req | output | 1 | One-cycle FIFO flush request |
| pfc_eff | output | 1 | Effective peripheral-flow bit after overrides |

## Verification
The bench builds the unit with CNT_W = 4, so the all-ones preset is 15. This brings every count value and every termination point within reach of an exhaustive sweep. All 128 combinations of direction, flow, circular, direct, double-buffer and burst bits are tried against a legality rule computed in the bench. Under DMA flow, every start count from 1 to 15 is run to zero in three directions. Under peripheral flow, the last request is issued after every possible number of beats that fits, and the items moved are compared with 15 minus the count.

// File: rtl/dma_term_pkg.sv
package dma_term_pkg;

  typedef enum logic [1:0] {
    DIR_P2M = 2'b00,
    DIR_M2P = 2'b01,
    DIR_M2M = 2'b10,
    DIR_RSV = 2'b11
  } dir_e;

  // Legality of a requested start; pfc_eff is the flow bit after override.
  function automatic logic cfg_legal(dir_e d, logic pfc_eff, logic circ,
                                     logic direct, logic dbuf, logic burst,
                                     logic cnt_zero);
    logic bad;
    bad = (d == DIR_RSV)
        | (pfc_eff & (circ | dbuf))
        | ((d == DIR_M2M) & (circ | dbuf | direct))
        | (direct & burst)
        | (!pfc_eff & cnt_zero);
    return !bad;
  endfunction

  // Items moved under peripheral flow: full-scale minus remaining.
  function automatic int unsigned items_moved(int unsigned w, int unsigned remain);
    return ((32'd1 << w) - 32'd1) - remain;
  endfunction

endpackage

// File: rtl/dma_term_cfgchk.sv
module dma_term_cfgchk
  import dma_term_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [1:0]       dir,
  input  logic             pfc_req,
  input  logic             circ,
  input  logic             direct,
  input  logic             dbuf,
  input  logic             burst,
  input  logic [CNT_W-1:0] cnt_now,
  output logic             pfc_eff,
  output logic             legal
);
  dir_e d;
  assign d       = dir_e'(dir);
  assign pfc_eff = pfc_req && (d != DIR_M2M);
  assign legal   = cfg_legal(d, pfc_eff, circ, direct, dbuf, burst, cnt_now == '0);
endmodule

// File: rtl/dma_term_counter.sv
module dma_term_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_load,
  input  logic [CNT_W-1:0] sw_val,
  input  logic             force_max,
  input  logic             dec,
  input  logic             reload,
  output logic [CNT_W-1:0] count,
  output logic             at_one
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] rel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      rel_q <= '0;
    end else begin
      if (force_max)    count <= CNT_MAX;
      else if (sw_load) count <= sw_val;
      else if (reload)  count <= rel_q;
      else if (dec)     count <= count - CNT_ONE;
      if (sw_load && !force_max) rel_q <= sw_val;
    end
  end

  assign at_one = (count == CNT_ONE);
endmodule

// File: rtl/dma_term_ctrl.sv
module dma_term_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_start,
  input  logic ev_stop,
  input  logic ev_tc,
  input  logic ev_reject,
  input  logic flush_set,
  input  logic tc_clr,
  input  logic err_clr,
  output logic active,
  output logic tc_flag,
  output logic cfg_err,
  output logic flush_req
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      tc_flag   <= 1'b0;
      cfg_err   <= 1'b0;
      flush_req <= 1'b0;
    end else begin
      if (ev_start)     active <= 1'b1;
      else if (ev_stop) active <= 1'b0;
      if (ev_tc)        tc_flag <= 1'b1;
      else if (tc_clr)  tc_flag <= 1'b0;
      if (ev_reject)    cfg_err <= 1'b1;
      else if (err_clr) cfg_err <= 1'b0;
      flush_req <= flush_set;
    end
  end
endmodule

// File: rtl/dma_term_unit.sv
module dma_term_unit
  import dma_term_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_en,
  input  logic [1:0]       cfg_dir,
  input  logic             cfg_pfc,
  input  logic             cfg_circ,
  input  logic             cfg_direct,
  input  logic             cfg_dbuf,
  input  logic             cfg_burst,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             tc_clr,
  input  logic             err_clr,
  input  logic             beat_done,
  input  logic             xfer_done,
  input  logic             last_sreq,
  input  logic             last_breq,
  output logic             active,
  output logic [CNT_W-1:0] count,
  output logic             tc_flag,
  output logic             cfg_err,
  output logic             flush_req,
  output logic             pfc_eff
);
  dir_e dir_q;
  logic pfc_q, circ_q, pend_last;
  logic pfc_in_eff, legal, at_one;

  // Named events, visible to the bound checker.
  logic ev_start, ev_reject, ev_abort, ev_zero, ev_lastdone;
  logic ev_wrap, ev_stop, ev_tc, flush_set, last_req;

  dma_term_cfgchk #(.CNT_W(CNT_W)) u_cfg (
    .dir(cfg_dir), .pfc_req(cfg_pfc), .circ(cfg_circ), .direct(cfg_direct),
    .dbuf(cfg_dbuf), .burst(cfg_burst), .cnt_now(count),
    .pfc_eff(pfc_in_eff), .legal(legal)
  );

  assign last_req    = last_sreq | last_breq;
  assign ev_start    = cfg_wr & cfg_en & !active & legal;
  assign ev_reject   = cfg_wr & cfg_en & !active & !legal;
  assign ev_abort    = cfg_wr & !cfg_en & active;
  assign ev_zero     = active & beat_done & at_one & !ev_abort;
  assign ev_lastdone = active & pfc_q & xfer_done & (pend_last | last_req) & !ev_abort;
  assign ev_wrap     = ev_zero & circ_q;
  assign ev_stop     = ev_abort | ev_lastdone | (ev_zero & !circ_q);
  assign ev_tc       = ev_abort | ev_lastdone | ev_zero;
  assign flush_set   = ev_abort & (dir_q == DIR_P2M);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q     <= DIR_P2M;
      pfc_q     <= 1'b0;
      circ_q    <= 1'b0;
      pend_last <= 1'b0;
    end else begin
      if (cfg_wr && !active) begin
        dir_q  <= dir_e'(cfg_dir);
        pfc_q  <= pfc_in_eff;
        circ_q <= cfg_circ;
      end
      if (ev_start || ev_stop)            pend_last <= 1'b0;
      else if (active && pfc_q && last_req) pend_last <= 1'b1;
    end
  end

  dma_term_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .sw_load(cnt_wr & !active), .sw_val(cnt_wdata),
    .force_max(ev_start & pfc_in_eff),
    .dec(active & beat_done & !ev_abort),
    .reload(ev_wrap),
    .count(count), .at_one(at_one)
  );

  dma_term_ctrl u_ctl (
    .clk(clk), .rst_n(rst_n),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_tc(ev_tc),
    .ev_reject(ev_reject), .flush_set(flush_set),
    .tc_clr(tc_clr), .err_clr(err_clr),
    .active(active), .tc_flag(tc_flag), .cfg_err(cfg_err), .flush_req(flush_req)
  );

  assign pfc_eff = pfc_q;
endmodule

// File: rtl/dma_term_sva.sv
module dma_term_sva #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic             cnt_wr,
  input logic             beat_done,
  input logic             xfer_done,
  input logic             active,
  input logic [CNT_W-1:0] count,
  input logic             tc_flag,
  input logic             cfg_err,
  input logic             flush_req,
  input logic             pfc_eff,
  input logic [1:0]       dir_q,
  input logic             ev_start,
  input logic             ev_reject,
  input logic             ev_abort,
  input logic             ev_zero,
  input logic             ev_lastdone,
  input logic             ev_stop
);
  // R5
  pfc_preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (!pfc_eff || count == {CNT_W{1'b1}}));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !cnt_wr && !cfg_wr) |=> $stable(count));

  // R4
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && beat_done && !ev_abort && count > CNT_W'(1)) |=> (count == $past(count) - CNT_W'(1)));

  // R9
  flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> (!active && $past(ev_abort)));

  // R2
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> (cfg_err && !active));

  // R3
  m2m_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && dir_q == 2'b10) |-> !pfc_eff);

  // R6
  tc_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_zero || ev_lastdone || ev_abort) |=> tc_flag);

  // R10
  stop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !active);

  // R8
  last_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && pfc_eff && !xfer_done && !ev_abort && !ev_zero) |=> active);
endmodule

bind dma_term_unit dma_term_sva #(.CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cnt_wr(cnt_wr),
  .beat_done(beat_done), .xfer_done(xfer_done), .active(active),
  .count(count), .tc_flag(tc_flag), .cfg_err(cfg_err), .flush_req(flush_req),
  .pfc_eff(pfc_eff), .dir_q(dir_q), .ev_start(ev_start), .ev_reject(ev_reject),
  .ev_abort(ev_abort), .ev_zero(ev_zero), .ev_lastdone(ev_lastdone),
  .ev_stop(ev_stop)
);

// File: tb/sim_dma_term_unit.sv
module sim_dma_term_unit;
  localparam int CNT_W = 4;
  localparam int FULL  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 0, cfg_en = 0, cfg_pfc = 0, cfg_circ = 0, cfg_direct = 0;
  logic cfg_dbuf = 0, cfg_burst = 0, cnt_wr = 0, tc_clr = 0, err_clr = 0;
  logic beat_done = 0, xfer_done = 0, last_sreq = 0, last_breq = 0;
  logic [1:0] cfg_dir = 2'b00;
  logic [CNT_W-1:0] cnt_wdata = '0;
  logic active, tc_flag, cfg_err, flush_req, pfc_eff;
  logic [CNT_W-1:0] count;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  dma_term_unit #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_dir(cfg_dir),
    .cfg_pfc(cfg_pfc), .cfg_circ(cfg_circ), .cfg_direct(cfg_direct),
    .cfg_dbuf(cfg_dbuf), .cfg_burst(cfg_burst), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata), .tc_clr(tc_clr), .err_clr(err_clr),
    .beat_done(beat_done), .xfer_done(xfer_done), .last_sreq(last_sreq),
    .last_breq(last_breq), .active(active), .count(count), .tc_flag(tc_flag),
    .cfg_err(cfg_err), .flush_req(flush_req), .pfc_eff(pfc_eff)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    cfg_wr = 0; cnt_wr = 0; beat_done = 0; xfer_done = 0;
    last_sreq = 0; last_breq = 0; tc_clr = 0; err_clr = 0;
  endtask

  task automatic wcnt(int v);
    cnt_wdata = CNT_W'(v); cnt_wr = 1; step();
  endtask

  task automatic wcfg(bit en, int dir, bit pfc, bit circ, bit direct, bit dbuf, bit burst);
    cfg_en = en; cfg_dir = 2'(dir); cfg_pfc = pfc; cfg_circ = circ;
    cfg_direct = direct; cfg_dbuf = dbuf; cfg_burst = burst; cfg_wr = 1;
    step();
  endtask

  task automatic clr();
    tc_clr = 1; err_clr = 1; step();
  endtask

  task automatic beat();
    beat_done = 1; step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    check("R1 active", active, 0);
    check("R1 count", count, 0);
    check("R1 tc", tc_flag, 0);
    check("R1 err", cfg_err, 0);
    check("R1 flush", flush_req, 0);

    // R2 legality sweep, R3 override
    for (int c = 0; c < 128; c++) begin
      bit pe, ok;
      int d;
      d  = c & 3;
      pe = c[2] && (d != 2);
      ok = !((d == 3) || (pe && (c[3] || c[5])) || (d == 2 && (c[3] || c[5] || c[4]))
             || (c[4] && c[6]));
      wcnt(5);
      wcfg(1, d, c[2], c[3], c[4], c[5], c[6]);
      check("R2 active", active, int'(ok));
      check("R2 err", cfg_err, int'(!ok));
      if (d == 2) check("R3 pfc_eff", pfc_eff, 0);
      else        check("R3 pfc_eff", pfc_eff, int'(c[2]));
      if (active) wcfg(0, d, c[2], c[3], c[4], c[5], c[6]);
      clr();
      check("R2 err_clr", cfg_err, 0);
    end
    wcnt(0);
    wcfg(1, 0, 0, 0, 0, 0, 0);
    check("R2 zero count DMA flow", cfg_err, 1);
    check("R2 zero count inactive", active, 0);
    clr();

    // R4 / R6 DMA-flow count sweep
    for (int d = 0; d < 3; d++) begin
      for (int n = 1; n <= FULL; n++) begin
        wcnt(n);
        wcfg(1, d, 0, 0, 0, 0, 0);
        check("R4 start count", count, n);
        check("R4 started", active, 1);
        for (int i = 1; i <= n; i++) begin
          beat();
          check("R4 count step", count, n - i);
          check("R6 active", active, int'(i < n));
        end
        check("R6 tc", tc_flag, 1);
        check("R6 no flush", flush_req, 0);
        clr();
      end
    end

    // R4 count write ignored while active, R8 last ignored in DMA flow
    wcnt(6);
    wcfg(1, 0, 0, 0, 0, 0, 0);
    wcnt(2);
    check("R4 write ignored", count, 6);
    last_sreq = 1; xfer_done = 1; beat_done = 1; step();
    check("R8 DMA ignores last active", active, 1);
    check("R8 DMA ignores last count", count, 5);
    wcfg(0, 0, 0, 0, 0, 0, 0);
    clr();

    // R5 / R8 peripheral-flow last request sweep
    for (int d = 0; d < 2; d++) begin
      for (int k = 0; k <= FULL - 2; k++) begin
        wcnt(3);
        wcfg(1, d, 1, 0, 0, 0, 0);
        check("R5 preset", count, FULL);
        for (int i = 0; i < k; i++) beat();
        if (k % 2 == 1) last_breq = 1; else last_sreq = 1;
        step();
        check("R8 held after last req", active, 1);
        beat_done = 1; xfer_done = 1; step();
        check("R8 stopped", active, 0);
        check("R8 tc", tc_flag, 1);
        check("R8 no flush", flush_req, 0);
        check("R8 moved", dma_term_pkg::items_moved(CNT_W, count), k + 1);
        check("R8 moved formula", FULL - int'(count), k + 1);
        clr();
      end
    end

    // R6 peripheral-flow overrun to zero
    wcnt(9);
    wcfg(1, 0, 1, 0, 0, 0, 0);
    for (int i = 1; i < FULL; i++) beat();
    check("R6 pfc before zero", active, 1);
    beat();
    check("R6 pfc forced off", active, 0);
    check("R6 pfc tc", tc_flag, 1);
    check("R6 pfc count", count, 0);
    clr();

    // R9 aborts
    for (int m = 0; m < 4; m++) begin
      int d;
      bit pfc;
      d = m & 1; pfc = m[1];
      wcnt(8);
      wcfg(1, d, pfc, 0, 0, 0, 0);
      repeat (3) beat();
      wcfg(0, d, pfc, 0, 0, 0, 0);
      check("R9 abort off", active, 0);
      check("R9 abort tc", tc_flag, 1);
      check("R9 flush", flush_req, int'(d == 0));
      check("R9 count kept", count, (pfc ? FULL : 8) - 3);
      step();
      check("R9 flush one cycle", flush_req, 0);
      clr();
    end

    // R7 circular
    wcnt(3);
    wcfg(1, 1, 0, 1, 0, 0, 0);
    for (int i = 1; i <= 9; i++) begin
      beat();
      check("R7 count", count, (i % 3 == 0) ? 3 : 3 - (i % 3));
      check("R7 active", active, 1);
      if (i == 3) begin
        check("R7 tc", tc_flag, 1);
        tc_clr = 1; step();
        check("R10 tc cleared", tc_flag, 0);
      end
    end
    wcfg(0, 1, 0, 1, 0, 0, 0);
    clr();

    // R10 set wins over clear, termination is final
    wcnt(1);
    wcfg(1, 1, 0, 0, 0, 0, 0);
    beat_done = 1; tc_clr = 1; step();
    check("R10 set wins", tc_flag, 1);
    check("R10 off", active, 0);
    beat();
    check("R10 no restart", active, 0);
    check("R10 count frozen", count, 0);
    tc_clr = 1; step();
    check("R10 w1c", tc_flag, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule